// File: doc/BRIEF.md
# Memory Attribute Remap Decoder

This block sits directly behind the lookup stage of an address translation cache. It takes the attribute bits carried by a translated page descriptor and produces the final memory attributes for the access. These attributes are the memory kind, the inner (level-one) caching policy, the outer caching policy and the shareability. It also produces the cache-attribute codes that go out on the bus. The outer attributes drive AXI-style read and write cache signals. The inner attributes drive a pair of sideband codes.

Two decode modes exist. The direct mode interprets all five type/cache bits of the descriptor. The remap mode uses only three of those bits, as an index into an eight-entry table that software programs. A separate shareability map completes the remap mode. Each security world has its own remap-enable bit, and the world of the current access picks which bit applies. The decode is purely combinational and sits after the translation lookup. A change to the tables or to the enables therefore reaches the next access without any flush of cached translations.

Top module: `mattr_remap_top`

## Requirements
- R1: With remap off for the current world, descriptor type bits `tex_i`=1xx give normal memory (kind code 10). The outer policy equals `tex_i[1:0]`, the inner policy equals `{c_i,b_i}`, and shared equals `s_i`. The policy codes are 00 non-cacheable, 01 write-back with allocate, 10 write-through and 11 write-back without allocate.
- R2: With remap off and `tex_i`=0xx, the decode uses `{tex_i[1:0],c_i,b_i}` as follows:
  - 0000 is strongly ordered (kind 00) and is always shared.
  - 0001 is device (kind 01) and is shared.
  - 0010 is normal, write-through inner and outer.
  - 0011 is normal, write-back without allocate inner and outer.
  - 0100 is normal non-cacheable.
  - 0111 is normal, write-back with allocate inner and outer.
  - 1000 is device and is not shared.
  - Every other code is normal non-cacheable.
  - The normal cases take shared from `s_i`. Every non-normal case has both policies 00.
- R3: When `has_fields_i` is 0, the type bits are taken as 000 and the share bit as 0, whatever `tex_i` and `s_i` carry.
- R4: With remap on, `{tex_i[0],c_i,b_i}` selects one of eight table entries, and kind, inner and outer come from that entry. `tex_i[2:1]` have no effect.
- R5: With remap on, shared equals bit `{kind,s}` of the 8-bit shareability map. Here kind is the 2-bit kind of the selected entry and s is the effective share bit. This holds for strongly ordered entries too.
- R6: The remap enable has two banked bits. Bit 1 applies when `secure_i`=1 and bit 0 applies when `secure_i`=0.
- R7: A write with `wr_en_i`=1 updates state at that clock edge, and the new value is seen from that edge onwards. The address map is:
  - Addresses 0..7 hold table entries, with data {kind[5:4], inner[3:2], outer[1:0]}.
  - Address 8 holds the shareability map.
  - Address 9 holds the enables, as data[1:0].
  - Writes to any other address change nothing.
- R8: Reset clears both enables. It loads the shareability map with 8'hAF and loads entries 0..7 so that remap mode gives the same result as direct mode for every descriptor with `tex_i[2:1]`=00.
- R9: Cache codes are as follows:
  - Strongly ordered gives 0000 and device gives 0001.
  - For normal memory (and kind 11), policy 00 gives 0011 and policy 01 gives 1111.
  - Policy 10 gives 1010 on read codes and 0110 on write codes.
  - Policy 11 gives 1011 on read codes and 0111 on write codes.
  - `arcache_o`/`awcache_o` use the outer policy, and `ar_inner_o`/`aw_inner_o` use the inner policy.
- R10: All attribute outputs follow changes of the descriptor and world inputs combinationally, in the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (4) | Register write address |
| wr_data_i | input | DATA_W (8) | Register write data |
| secure_i | input | 1 | Access belongs to the secure world |
| has_fields_i | input | 1 | Descriptor format carries type and share fields |
| tex_i | input | 3 | Descriptor type-extension bits |
| c_i | input | 1 | Descriptor cacheable bit |
| b_i | input | 1 | Descriptor bufferable bit |
| s_i | input | 1 | Descriptor share bit |
| mem_kind_o | output | 2 | Memory kind: 00 strongly ordered, 01 device, 10 normal |
| inner_pol_o | output | 2 | Inner caching policy |
| outer_pol_o | output | 2 | Outer caching policy |
| shared_o | output | 1 | Shareable |
| arcache_o | output | 4 | Read cache code, outer |
| awcache_o | output | 4 | Write cache code, outer |
| ar_inner_o | output | 4 | Read sideband code, inner |
| aw_inner_o | output | 4 | Write sideband code, inner |

## Verification
The assertions check the following on every cycle:
- the direct decode of high type codes;
- the forced sharing of strongly ordered memory in direct mode;
- the type override when a descriptor has no type field;
- the zero cache codes of strongly ordered accesses;
- the arrival of an enable write one edge later.

The bench scenarios cover what needs chosen register contents and walked descriptor patterns. These are the equivalence between reset tables and direct decode, and the inertness of the upper type bits under remap. They also include the per-world bank selection, the shareability-map override and the silence of unmapped addresses.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    localparam int N_ENTRIES = 8;
    localparam int IDX_W     = $clog2(N_ENTRIES);
    localparam int SHMAP_W   = 8;
    localparam int ENA_W     = 2;

    typedef enum logic [1:0] {
        MK_STRONG = 2'b00,
        MK_DEVICE = 2'b01,
        MK_NORMAL = 2'b10,
        MK_RSVD   = 2'b11
    } mem_kind_e;

    typedef enum logic [1:0] {
        CP_NONE       = 2'b00,
        CP_WB_ALLOC   = 2'b01,
        CP_WTHRU      = 2'b10,
        CP_WB_NOALLOC = 2'b11
    } cache_pol_e;

    typedef struct packed {
        mem_kind_e  kind;
        cache_pol_e inner;
        cache_pol_e outer;
    } rmp_entry_t;

    localparam int ENTRY_W = $bits(rmp_entry_t);

    typedef struct packed {
        mem_kind_e  kind;
        cache_pol_e inner;
        cache_pol_e outer;
        logic       shared;
    } mem_attr_t;

    // Reset content: reproduces direct decode for type bits 00x.
    function automatic rmp_entry_t rst_entry(input logic [IDX_W-1:0] idx);
        rmp_entry_t e;
        e.kind  = MK_NORMAL;
        e.inner = CP_NONE;
        e.outer = CP_NONE;
        case (idx)
            3'd0: e.kind = MK_STRONG;
            3'd1: e.kind = MK_DEVICE;
            3'd2: begin e.inner = CP_WTHRU;      e.outer = CP_WTHRU;      end
            3'd3: begin e.inner = CP_WB_NOALLOC; e.outer = CP_WB_NOALLOC; end
            3'd7: begin e.inner = CP_WB_ALLOC;   e.outer = CP_WB_ALLOC;   end
            default: ;
        endcase
        return e;
    endfunction

    localparam logic [SHMAP_W-1:0] SHMAP_RST = 8'hAF;

    // Bus cache code for one policy; wr selects the write-side form.
    function automatic logic [3:0] ax_code(input mem_kind_e k, input cache_pol_e p,
                                           input logic wr);
        logic [3:0] code;
        if (k == MK_STRONG)      code = 4'b0000;
        else if (k == MK_DEVICE) code = 4'b0001;
        else begin
            case (p)
                CP_NONE:       code = 4'b0011;
                CP_WB_ALLOC:   code = 4'b1111;
                CP_WTHRU:      code = wr ? 4'b0110 : 4'b1010;
                default:       code = wr ? 4'b0111 : 4'b1011;
            endcase
        end
        return code;
    endfunction

endpackage

// File: rtl/mattr_regs.sv
module mattr_regs
    import mattr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en_i,
    input  logic [ADDR_W-1:0]                  wr_addr_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    output rmp_entry_t [N_ENTRIES-1:0]         table_o,
    output logic [SHMAP_W-1:0]                 shmap_o,
    output logic [ENA_W-1:0]                   ena_o
);
    localparam int SHMAP_ADDR = N_ENTRIES;
    localparam int ENA_ADDR   = N_ENTRIES + 1;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                table_o[i] <= rst_entry(IDX_W'(i));
            else if (wr_en_i && wr_addr_i == ADDR_W'(i))
                table_o[i] <= rmp_entry_t'(wr_data_i[ENTRY_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shmap_o <= SHMAP_RST;
            ena_o   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(SHMAP_ADDR)) shmap_o <= wr_data_i[SHMAP_W-1:0];
            if (wr_addr_i == ADDR_W'(ENA_ADDR))   ena_o   <= wr_data_i[ENA_W-1:0];
        end
    end
endmodule

// File: rtl/mattr_direct_dec.sv
module mattr_direct_dec
    import mattr_pkg::*;
(
    input  logic [2:0] tex_i,
    input  logic       c_i,
    input  logic       b_i,
    input  logic       s_i,
    output mem_attr_t  attr_o
);
    always_comb begin
        attr_o.kind   = MK_NORMAL;
        attr_o.inner  = CP_NONE;
        attr_o.outer  = CP_NONE;
        attr_o.shared = s_i;
        if (tex_i[2]) begin
            attr_o.outer = cache_pol_e'(tex_i[1:0]);
            attr_o.inner = cache_pol_e'({c_i, b_i});
        end else begin
            case ({tex_i[1:0], c_i, b_i})
                4'b0000: begin attr_o.kind = MK_STRONG; attr_o.shared = 1'b1; end
                4'b0001: begin attr_o.kind = MK_DEVICE; attr_o.shared = 1'b1; end
                4'b0010: begin attr_o.inner = CP_WTHRU;      attr_o.outer = CP_WTHRU;      end
                4'b0011: begin attr_o.inner = CP_WB_NOALLOC; attr_o.outer = CP_WB_NOALLOC; end
                4'b0111: begin attr_o.inner = CP_WB_ALLOC;   attr_o.outer = CP_WB_ALLOC;   end
                4'b1000: begin attr_o.kind = MK_DEVICE; attr_o.shared = 1'b0; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mattr_remap_dec.sv
module mattr_remap_dec
    import mattr_pkg::*;
(
    input  logic [IDX_W-1:0]           idx_i,
    input  logic                       s_i,
    input  rmp_entry_t [N_ENTRIES-1:0] table_i,
    input  logic [SHMAP_W-1:0]         shmap_i,
    output mem_attr_t                  attr_o
);
    rmp_entry_t sel;

    always_comb begin
        sel           = table_i[idx_i];
        attr_o.kind   = sel.kind;
        attr_o.inner  = sel.inner;
        attr_o.outer  = sel.outer;
        attr_o.shared = shmap_i[{sel.kind, s_i}];
    end
endmodule

// File: rtl/mattr_remap_top.sv
module mattr_remap_top
    import mattr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              secure_i,
    input  logic              has_fields_i,
    input  logic [2:0]        tex_i,
    input  logic              c_i,
    input  logic              b_i,
    input  logic              s_i,
    output logic [1:0]        mem_kind_o,
    output logic [1:0]        inner_pol_o,
    output logic [1:0]        outer_pol_o,
    output logic              shared_o,
    output logic [3:0]        arcache_o,
    output logic [3:0]        awcache_o,
    output logic [3:0]        ar_inner_o,
    output logic [3:0]        aw_inner_o
);
    rmp_entry_t [N_ENTRIES-1:0] table_q;
    logic [SHMAP_W-1:0]         shmap_q;
    logic [ENA_W-1:0]           ena_q;

    logic [2:0] eff_tex;
    logic       eff_s;
    logic       remap_on;
    mem_attr_t  attr_dir, attr_rmp, attr_fin;

    mattr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .table_o   (table_q),
        .shmap_o   (shmap_q),
        .ena_o     (ena_q)
    );

    assign eff_tex  = has_fields_i ? tex_i : 3'b000;
    assign eff_s    = has_fields_i & s_i;
    assign remap_on = secure_i ? ena_q[1] : ena_q[0];

    mattr_direct_dec u_dir (
        .tex_i  (eff_tex),
        .c_i    (c_i),
        .b_i    (b_i),
        .s_i    (eff_s),
        .attr_o (attr_dir)
    );

    mattr_remap_dec u_rmp (
        .idx_i   ({eff_tex[0], c_i, b_i}),
        .s_i     (eff_s),
        .table_i (table_q),
        .shmap_i (shmap_q),
        .attr_o  (attr_rmp)
    );

    assign attr_fin    = remap_on ? attr_rmp : attr_dir;
    assign mem_kind_o  = attr_fin.kind;
    assign inner_pol_o = attr_fin.inner;
    assign outer_pol_o = attr_fin.outer;
    assign shared_o    = attr_fin.shared;

    assign arcache_o  = ax_code(attr_fin.kind, attr_fin.outer, 1'b0);
    assign awcache_o  = ax_code(attr_fin.kind, attr_fin.outer, 1'b1);
    assign ar_inner_o = ax_code(attr_fin.kind, attr_fin.inner, 1'b0);
    assign aw_inner_o = ax_code(attr_fin.kind, attr_fin.inner, 1'b1);
endmodule

// File: rtl/mattr_remap_chk.sv
module mattr_remap_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              secure_i,
    input logic              has_fields_i,
    input logic [2:0]        tex_i,
    input logic              c_i,
    input logic              b_i,
    input logic              s_i,
    input logic [1:0]        ena_q,
    input logic [1:0]        mem_kind_o,
    input logic [1:0]        inner_pol_o,
    input logic [1:0]        outer_pol_o,
    input logic              shared_o,
    input logic [3:0]        arcache_o,
    input logic [3:0]        awcache_o,
    input logic [3:0]        ar_inner_o,
    input logic [3:0]        aw_inner_o
);
    localparam logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(9);

    logic bank_on;
    assign bank_on = secure_i ? ena_q[1] : ena_q[0];

    a_r1_high_tex: assert property (@(posedge clk) disable iff (rst)
        (!bank_on && has_fields_i && tex_i[2]) |->
        (mem_kind_o == 2'b10 && outer_pol_o == tex_i[1:0] &&
         inner_pol_o == {c_i, b_i} && shared_o == s_i));

    a_r2_strong_shared: assert property (@(posedge clk) disable iff (rst)
        (!bank_on && mem_kind_o == 2'b00) |-> shared_o);

    a_r3_no_fields: assert property (@(posedge clk) disable iff (rst)
        (!bank_on && !has_fields_i && c_i) |->
        (mem_kind_o == 2'b10 && !shared_o));

    a_r9_strong_codes: assert property (@(posedge clk) disable iff (rst)
        (mem_kind_o == 2'b00) |->
        (arcache_o == 4'b0000 && awcache_o == 4'b0000 &&
         ar_inner_o == 4'b0000 && aw_inner_o == 4'b0000));

    a_r7_enable_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == ENA_ADDR) |=> (ena_q == $past(wr_data_i[1:0])));
endmodule

bind mattr_remap_top mattr_remap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .secure_i     (secure_i),
    .has_fields_i (has_fields_i),
    .tex_i        (tex_i),
    .c_i          (c_i),
    .b_i          (b_i),
    .s_i          (s_i),
    .ena_q        (ena_q),
    .mem_kind_o   (mem_kind_o),
    .inner_pol_o  (inner_pol_o),
    .outer_pol_o  (outer_pol_o),
    .shared_o     (shared_o),
    .arcache_o    (arcache_o),
    .awcache_o    (awcache_o),
    .ar_inner_o   (ar_inner_o),
    .aw_inner_o   (aw_inner_o)
);

// File: tb/mattr_remap_top_tb_top.sv
`timescale 1ns/1ps
module mattr_remap_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       secure = 1'b0;
    logic       has = 1'b1;
    logic [2:0] tex = '0;
    logic       c = 1'b0, b = 1'b0, s = 1'b0;
    logic [1:0] kind, inner, outer;
    logic       shared;
    logic [3:0] arc, awc, ari, awi;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mattr_remap_top dut_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .secure_i(secure), .has_fields_i(has), .tex_i(tex), .c_i(c), .b_i(b), .s_i(s),
        .mem_kind_o(kind), .inner_pol_o(inner), .outer_pol_o(outer), .shared_o(shared),
        .arcache_o(arc), .awcache_o(awc), .ar_inner_o(ari), .aw_inner_o(awi)
    );

    // {has, tex[2:0], c, b, s, kind, inner, outer, shared}
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        14'b1_000_0_0_0_00_00_00_1,
        14'b1_000_0_1_0_01_00_00_1,
        14'b1_000_1_0_1_10_10_10_1,
        14'b1_000_1_1_0_10_11_11_0,
        14'b1_001_0_0_1_10_00_00_1,
        14'b1_001_1_1_0_10_01_01_0,
        14'b1_010_0_0_1_01_00_00_0,
        14'b1_011_1_0_1_10_00_00_1,
        14'b1_100_1_1_1_10_11_00_1,
        14'b1_101_1_0_0_10_10_01_0,
        14'b1_110_0_1_1_10_01_10_1,
        14'b1_111_0_0_0_10_00_11_0,
        14'b0_111_1_0_1_10_10_10_0,
        14'b0_010_0_0_0_00_00_00_1,
        14'b0_100_1_1_1_10_11_11_0,
        14'b1_001_0_1_1_10_00_00_1
    };

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic h, input logic [2:0] t, input logic cc,
                         input logic bb, input logic ss);
        has = h; tex = t; c = cc; b = bb; s = ss;
        #1;
    endtask

    task automatic check_attr(input string req, input logic [6:0] exp);
        check(req, "attr {kind,inner,outer,shared}", {25'd0, kind, inner, outer, shared},
              {25'd0, exp});
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic walk_table(input bit only_low);
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            string tag;
            v = VEC[i];
            if (!only_low || (v[13] && v[12:11] == 2'b00)) begin
                tag = !v[13] ? "R3" : (v[12] ? "R1" : "R2");
                if (only_low) tag = "R8";
                drive(v[13], v[12:10], v[9], v[8], v[7]);
                check(tag, "vector attr", {25'd0, kind, inner, outer, shared}, {25'd0, v[6:0]});
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog R10 actual=%0d expected<100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state: both enables clear, so direct decode visible in both worlds
        secure = 1'b1;
        drive(1, 3'b101, 1, 1, 1);
        check_attr("R8", 7'b10_11_01_1);
        secure = 1'b0;
        drive(1, 3'b101, 1, 1, 1);
        check_attr("R8", 7'b10_11_01_1);

        // R1, R2, R3, R10: table walk, inputs change with no clock edge
        walk_table(0);

        // R9 cache codes
        drive(1, 3'b000, 0, 0, 0);
        check("R9", "strong codes", {16'd0, arc, awc, ari, awi}, 32'h0000);
        drive(1, 3'b000, 0, 1, 0);
        check("R9", "device codes", {16'd0, arc, awc, ari, awi}, 32'h1111);
        drive(1, 3'b000, 1, 0, 0);
        check("R9", "write-through codes", {16'd0, arc, awc, ari, awi}, 32'hA6A6);
        drive(1, 3'b101, 1, 1, 0);
        check("R9", "wb-alloc outer, wb-noalloc inner", {16'd0, arc, awc, ari, awi}, 32'hFFB7);
        drive(1, 3'b100, 0, 0, 0);
        check("R9", "non-cacheable codes", {16'd0, arc, awc, ari, awi}, 32'h3333);

        // R8: reset tables equal direct decode for type bits 00x
        do_write(4'd9, 8'h03);
        secure = 1'b1; walk_table(1);
        secure = 1'b0; walk_table(1);

        // R4: program entry 3 = normal, inner wb-alloc, outer write-through
        do_write(4'd3, 8'b00_10_01_10);
        drive(1, 3'b000, 1, 1, 0);
        check_attr("R4", 7'b10_01_10_0);
        drive(1, 3'b110, 1, 1, 0);
        check_attr("R4", 7'b10_01_10_0);
        drive(1, 3'b111, 1, 1, 0);
        check_attr("R4", 7'b10_01_01_0);

        // R5: shareability map; normal S0->1, S1->0, strongly ordered not shared
        do_write(4'd8, 8'b0001_0000);
        drive(1, 3'b000, 1, 1, 0);
        check("R5", "normal s=0 shared", {31'd0, shared}, 32'd1);
        drive(1, 3'b000, 1, 1, 1);
        check("R5", "normal s=1 shared", {31'd0, shared}, 32'd0);
        drive(1, 3'b000, 0, 0, 1);
        check_attr("R5", 7'b00_00_00_0);

        // R6: banked enables
        do_write(4'd9, 8'h02);
        secure = 1'b1; drive(1, 3'b000, 1, 1, 0);
        check_attr("R6", 7'b10_01_10_1);
        secure = 1'b0; drive(1, 3'b000, 1, 1, 0);
        check_attr("R6", 7'b10_11_11_0);
        do_write(4'd9, 8'h01);
        secure = 1'b1; drive(1, 3'b000, 1, 1, 0);
        check_attr("R6", 7'b10_11_11_0);
        secure = 1'b0; drive(1, 3'b000, 1, 1, 0);
        check_attr("R6", 7'b10_01_10_1);

        // R7: unmapped address changes nothing
        do_write(4'd12, 8'h00);
        drive(1, 3'b000, 1, 1, 0);
        check_attr("R7", 7'b10_01_10_1);
        secure = 1'b1; drive(1, 3'b000, 1, 1, 0);
        check_attr("R7", 7'b10_11_11_0);
        secure = 1'b0;

        // R7: timing of a write; old value before the edge, new value after
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'b00_10_10_11;
        drive(1, 3'b000, 1, 1, 0);
        check_attr("R7", 7'b10_01_10_1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check_attr("R7", 7'b10_10_11_1);

        // R3 under remap: type bits forced to 000, share forced to 0
        drive(0, 3'b111, 1, 1, 1);
        check_attr("R3", 7'b10_10_11_1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule